// File: doc/BRIEF.md
# Dual-Buffer Transmit Frame Controller

This block is the transmit half of a small Ethernet MAC. Software sees one or two transmit slots, each made of a word-wide frame store, a 16-bit length register and a control/status register, all reached through a simple write port and a combinational read port. To send a frame, software fills a slot's store with 32-bit words, writes the byte count and sets the slot's busy bit. A single shared byte streamer then drains the slot on a byte-wide valid/ready interface and clears busy when the last byte has been accepted. Framing, checksum and line coding are left to the stages downstream.

The same path also sets the station address. If a slot is started with both the busy bit and the program bit set, no bytes go out. Instead the first six bytes of that slot are copied into the station-address register and both bits clear. When two slots are in use they are served in the order they were started, and a slot started while the other is streaming waits for that frame to finish. Each completion can raise a one-cycle interrupt pulse if the slot's interrupt-enable bit is set.

Address map (word address): the top bit picks the slot, the next bit picks register space (1) or frame store (0). In register space, index 0 is the length register and index 1 is the control/status register. In frame-store space, the low bits are the word index.

Top module: `tx_dual_buf_ctrl`

## Requirements
- R1: After reset, every length and control/status register reads zero, `tx_valid` and `irq` are low and `station_addr` is zero.
- R2: Writing a control/status value with bit 0 (busy) set streams exactly `length` bytes from that slot, in ascending byte address order, taking byte lanes 7:0, 15:8, 23:16, 31:24 of each word in turn. Busy reads back as 0 once the frame is done.
- R3: `tx_last` is high together with `tx_valid` on byte number length-1 of a frame and on no other byte.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values until the byte is accepted.
- R5: The length register keeps bits 15:0 of the written word and reads back with bits 31:16 zero.
- R6: A length of zero finishes the request with busy cleared and no byte presented.
- R7: Starting a slot with bits 0 and 1 both set loads its first six bytes into `station_addr`, byte 0 in bits 7:0 up to byte 5 in bits 47:40. No byte is streamed, and bits 0 and 1 both read back 0 afterwards.
- R8: When bit 3 (interrupt enable) of a slot is set, each completion of that slot gives a single-cycle pulse on `irq`. When bit 3 is clear, completion gives no pulse.
- R9: A control/status write with bit 0 clear cancels that slot. A pending request is never streamed. A frame that is streaming drops `tx_valid` in the next cycle, and no `irq` pulse is given.
- R10: With two slots, a slot started while the other is streaming is sent after that frame completes, and requests are served in the order they were started.
- R11: With the slot count parameter set to 1, accesses to the second slot are ignored: its registers read zero and starting it streams nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register/store port |
| wr_addr | input | ADDR_W | Write word address (slot, space, index) |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | 32 | Combinational read data |
| tx_valid | output | 1 | Byte available on `tx_data` |
| tx_ready | input | 1 | Downstream accepts the current byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Current byte ends the frame |
| irq | output | 1 | One-cycle completion pulse |
| station_addr | output | 48 | Programmed station address |

## Verification
The main instance is built with two slots and an eight-word store. This brings ordering, waiting behind an active frame, and cancelling either the active or the pending slot within reach, and lets a frame fill the store exactly (32 bytes). A second instance with a single slot and the same store size shares the write and read stimulus. It shows that the second slot's registers are absent and that starting that slot produces no traffic.

// File: rtl/tx_dual_pkg.sv
package tx_dual_pkg;
   localparam int CS_BUSY = 0;
   localparam int CS_PROG = 1;
   localparam int CS_IE   = 3;

   localparam int REG_LEN  = 0;
   localparam int REG_CTRL = 1;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_FIN  = 2'd2
   } strm_state_e;
endpackage

// File: rtl/tx_buf_slot.sv
module tx_buf_slot
   import tx_dual_pkg::*;
#(
   parameter int DEPTH_WORDS = 8,
   parameter int WAW         = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ram_we,
   input  logic           len_we,
   input  logic           ctrl_we,
   input  logic [WAW-1:0] wr_idx,
   input  logic [31:0]    wr_data,
   input  logic           done,
   input  logic [WAW-1:0] strm_idx,
   input  logic [WAW-1:0] host_idx,
   output logic [31:0]    strm_word,
   output logic [31:0]    host_word,
   output logic [31:0]    word0,
   output logic [15:0]    word1_lo,
   output logic [15:0]    length,
   output logic           busy,
   output logic           prog,
   output logic           ie,
   output logic           arm
);
   logic [31:0] mem [DEPTH_WORDS];

   always_ff @(posedge clk) begin
      if (ram_we) mem[wr_idx] <= wr_data;
   end

   assign strm_word = mem[strm_idx];
   assign host_word = mem[host_idx];
   assign word0     = mem[0];
   assign word1_lo  = mem[1][15:0];

   assign arm = ctrl_we && wr_data[CS_BUSY] && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         length <= '0;
         busy   <= 1'b0;
         prog   <= 1'b0;
         ie     <= 1'b0;
      end else begin
         if (len_we) length <= wr_data[15:0];
         if (ctrl_we) begin
            busy <= wr_data[CS_BUSY];
            prog <= wr_data[CS_PROG];
            ie   <= wr_data[CS_IE];
         end else if (done) begin
            busy <= 1'b0;
            prog <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tx_arb_order.sv
module tx_arb_order (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] busy,
   input  logic [1:0] arm,
   output logic       pick_valid,
   output logic       pick_idx
);
   logic older_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      older_q <= 1'b0;
      else if (arm[1]) older_q <= busy[0] ? 1'b0 : 1'b1;
      else if (arm[0]) older_q <= busy[1] ? 1'b1 : 1'b0;
   end

   assign pick_valid = |busy;
   assign pick_idx   = (&busy) ? older_q : busy[1];
endmodule

// File: rtl/tx_byte_stream.sv
module tx_byte_stream
   import tx_dual_pkg::*;
#(
   parameter int WAW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pick_valid,
   input  logic           pick_idx,
   input  logic [15:0]    len,
   input  logic           prog,
   input  logic [31:0]    word,
   input  logic [31:0]    word0,
   input  logic [15:0]    word1_lo,
   input  logic           tx_ready,
   input  logic           cancel,
   output logic           tx_valid,
   output logic [7:0]     tx_data,
   output logic           tx_last,
   output logic [WAW-1:0] rd_widx,
   output logic           cur_idx,
   output logic           done,
   output logic [47:0]    station_addr
);
   strm_state_e st_q;
   logic        act_q;
   logic [15:0] cnt_q;
   logic        at_end;

   assign at_end   = (cnt_q == len - 16'd1);
   assign tx_valid = (st_q == ST_SEND);
   assign tx_last  = tx_valid && at_end;
   assign tx_data  = word[{cnt_q[1:0], 3'b000} +: 8];
   assign rd_widx  = cnt_q[WAW+1:2];
   assign cur_idx  = (st_q == ST_IDLE) ? pick_idx : act_q;
   assign done     = (st_q == ST_FIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         act_q        <= 1'b0;
         cnt_q        <= '0;
         station_addr <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (pick_valid) begin
               act_q <= pick_idx;
               cnt_q <= '0;
               if (prog) begin
                  station_addr <= {word1_lo, word0};
                  st_q         <= ST_FIN;
               end else if (len == 16'd0) begin
                  st_q <= ST_FIN;
               end else begin
                  st_q <= ST_SEND;
               end
            end
            ST_SEND: if (cancel) begin
               st_q <= ST_IDLE;
            end else if (tx_ready) begin
               if (at_end) st_q  <= ST_FIN;
               else        cnt_q <= cnt_q + 16'd1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tx_dual_buf_ctrl.sv
module tx_dual_buf_ctrl
   import tx_dual_pkg::*;
#(
   parameter int NBUF        = 2,
   parameter int DEPTH_WORDS = 8,
   parameter int ADDR_W      = $clog2(DEPTH_WORDS) + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   output logic              irq,
   output logic [47:0]       station_addr
);
   localparam int WAW = $clog2(DEPTH_WORDS);

   if (NBUF < 1 || NBUF > 2) begin : g_bad_nbuf
      $error("NBUF must be 1 or 2");
   end
   if (DEPTH_WORDS < 2 || (1 << WAW) != DEPTH_WORDS || WAW + 2 > 16) begin : g_bad_depth
      $error("DEPTH_WORDS must be a power of two from 2 to 16384");
   end
   if (ADDR_W != WAW + 2) begin : g_bad_aw
      $error("ADDR_W must equal clog2(DEPTH_WORDS)+2");
   end

   logic           w_slot, w_regs, r_slot, r_regs;
   logic [WAW-1:0] w_idx, r_idx;
   assign w_slot = wr_addr[ADDR_W-1];
   assign w_regs = wr_addr[ADDR_W-2];
   assign w_idx  = wr_addr[WAW-1:0];
   assign r_slot = rd_addr[ADDR_W-1];
   assign r_regs = rd_addr[ADDR_W-2];
   assign r_idx  = rd_addr[WAW-1:0];

   logic [31:0]    s_word [2];
   logic [31:0]    h_word [2];
   logic [31:0]    s_w0   [2];
   logic [15:0]    s_w1   [2];
   logic [15:0]    s_len  [2];
   logic [1:0]     busy_v, prog_v, ie_v, arm_v;
   logic           pick_valid, pick_idx, cur_idx, done, cancel;
   logic [WAW-1:0] rd_widx;
   logic           irq_q;

   assign cancel = wr_en && w_regs && (w_idx == WAW'(REG_CTRL))
                   && (w_slot == cur_idx) && !wr_data[CS_BUSY];

   for (genvar g = 0; g < 2; g++) begin : g_slot
      if (g < NBUF) begin : g_on
         logic sel;
         assign sel = wr_en && (w_slot == 1'(g));
         tx_buf_slot #(.DEPTH_WORDS(DEPTH_WORDS), .WAW(WAW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .ram_we   (sel && !w_regs),
            .len_we   (sel && w_regs && (w_idx == WAW'(REG_LEN))),
            .ctrl_we  (sel && w_regs && (w_idx == WAW'(REG_CTRL))),
            .wr_idx   (w_idx),
            .wr_data  (wr_data),
            .done     (done && (cur_idx == 1'(g))),
            .strm_idx (rd_widx),
            .host_idx (r_idx),
            .strm_word(s_word[g]),
            .host_word(h_word[g]),
            .word0    (s_w0[g]),
            .word1_lo (s_w1[g]),
            .length   (s_len[g]),
            .busy     (busy_v[g]),
            .prog     (prog_v[g]),
            .ie       (ie_v[g]),
            .arm      (arm_v[g])
         );
      end else begin : g_off
         assign s_word[g] = '0;
         assign h_word[g] = '0;
         assign s_w0[g]   = '0;
         assign s_w1[g]   = '0;
         assign s_len[g]  = '0;
         assign busy_v[g] = 1'b0;
         assign prog_v[g] = 1'b0;
         assign ie_v[g]   = 1'b0;
         assign arm_v[g]  = 1'b0;
      end
   end

   tx_arb_order u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy_v),
      .arm       (arm_v),
      .pick_valid(pick_valid),
      .pick_idx  (pick_idx)
   );

   tx_byte_stream #(.WAW(WAW)) u_strm (
      .clk         (clk),
      .rst_n       (rst_n),
      .pick_valid  (pick_valid),
      .pick_idx    (pick_idx),
      .len         (s_len[cur_idx]),
      .prog        (prog_v[cur_idx]),
      .word        (s_word[cur_idx]),
      .word0       (s_w0[cur_idx]),
      .word1_lo    (s_w1[cur_idx]),
      .tx_ready    (tx_ready),
      .cancel      (cancel),
      .tx_valid    (tx_valid),
      .tx_data     (tx_data),
      .tx_last     (tx_last),
      .rd_widx     (rd_widx),
      .cur_idx     (cur_idx),
      .done        (done),
      .station_addr(station_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= done && ie_v[cur_idx] && !cancel;
   end
   assign irq = irq_q;

   always_comb begin
      rd_data = '0;
      if (!r_regs) begin
         rd_data = h_word[r_slot];
      end else if (r_idx == WAW'(REG_LEN)) begin
         rd_data = {16'd0, s_len[r_slot]};
      end else if (r_idx == WAW'(REG_CTRL)) begin
         rd_data[CS_BUSY] = busy_v[r_slot];
         rd_data[CS_PROG] = prog_v[r_slot];
         rd_data[CS_IE]   = ie_v[r_slot];
      end
   end
endmodule

// File: rtl/tx_dual_chk.sv
module tx_dual_chk #(
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wr_bit0,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic [7:0]        tx_data,
   input logic              tx_last,
   input logic              irq,
   input logic [1:0]        busy,
   input logic              act_idx,
   input logic              done
);
   logic ctrl_wr, touch_act, cancel_act;
   assign ctrl_wr    = wr_en && wr_addr[ADDR_W-2] && (wr_addr[ADDR_W-3:0] == 1);
   assign touch_act  = wr_en && (wr_addr[ADDR_W-1] == act_idx);
   assign cancel_act = ctrl_wr && (wr_addr[ADDR_W-1] == act_idx) && !wr_bit0;

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready && !touch_act |=> tx_valid && $stable(tx_data) && $stable(tx_last));

   assert_last_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);

   assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   assert_cancel_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && cancel_act |=> !tx_valid);

   assert_busy0_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[0]) |-> $past(done && !act_idx) || $past(ctrl_wr && !wr_addr[ADDR_W-1]));

   assert_busy1_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[1]) |-> $past(done && act_idx) || $past(ctrl_wr && wr_addr[ADDR_W-1]));
endmodule

bind tx_dual_buf_ctrl tx_dual_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_bit0 (wr_data[0]),
   .tx_valid(tx_valid),
   .tx_ready(tx_ready),
   .tx_data (tx_data),
   .tx_last (tx_last),
   .irq     (irq),
   .busy    (busy_v),
   .act_idx (cur_idx),
   .done    (done)
);

// File: tb/test_tx_dual_buf_ctrl.sv
module test_tx_dual_buf_ctrl;
   localparam int DW = 8;
   localparam int AW = $clog2(DW) + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0]   rd_data, s_rd_data;
   logic          tx_valid, tx_ready, tx_last, irq;
   logic [7:0]    tx_data;
   logic [47:0]   station_addr;
   logic          s_tx_valid, s_tx_last, s_irq;
   logic [7:0]    s_tx_data;
   logic [47:0]   s_station;

   tx_dual_buf_ctrl #(.NBUF(2), .DEPTH_WORDS(DW)) i_tx_dual_buf_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_data(tx_data), .tx_last(tx_last), .irq(irq), .station_addr(station_addr));

   tx_dual_buf_ctrl #(.NBUF(1), .DEPTH_WORDS(DW)) i_tx_dual_buf_ctrl_single (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(s_rd_data), .tx_valid(s_tx_valid), .tx_ready(1'b1),
      .tx_data(s_tx_data), .tx_last(s_tx_last), .irq(s_irq), .station_addr(s_station));

   always #4 clk = ~clk;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [7:0] cap_d [64];
   logic       cap_l [64];
   int cap_n = 0;
   int irq_cnt = 0;
   int s_valid_cnt = 0;

   always @(posedge clk) begin
      if (rst_n && tx_valid && tx_ready && cap_n < 64) begin
         cap_d[cap_n] = tx_data;
         cap_l[cap_n] = tx_last;
         cap_n++;
      end
      if (rst_n && irq) irq_cnt++;
      if (rst_n && s_tx_valid) s_valid_cnt++;
   end

   // slot, register space, index
   function automatic logic [AW-1:0] adr(input int slot, input bit regs, input int idx);
      return {slot[0], regs, idx[AW-3:0]};
   endfunction

   function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
      return 8'(seed + i * 13);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      rd_addr = a; #1; d = rd_data;
   endtask

   task automatic fill(input int slot, input int len, input logic [7:0] seed);
      for (int w = 0; w < (len + 3) / 4; w++) begin
         logic [31:0] word = '0;
         for (int b = 0; b < 4; b++)
            if (w * 4 + b < len) word[b*8 +: 8] = pat(seed, w * 4 + b);
         wr(adr(slot, 1'b0, w), word);
      end
   endtask

   task automatic wait_idle(input int slot);
      logic [31:0] v;
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         rd(adr(slot, 1'b1, 1), v);
         if (v[0] == 1'b0) break;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic cmp_frame(input int base, input int len, input logic [7:0] seed, input string req);
      for (int i = 0; i < len; i++) begin
         check(cap_d[base+i] == pat(seed, i), req, cap_d[base+i], pat(seed, i));
         check(cap_l[base+i] == (i == len - 1), "R3 last flag", cap_l[base+i], i == len - 1);
      end
   endtask

   localparam logic [31:0] VEC [6] = '{
      32'h0311_0001, 32'h0122_0004, 32'h0033_0005,
      32'h035A_0007, 32'h0077_0020, 32'h01C1_0003 };

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int i0;
      tx_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int s = 0; s < 2; s++) begin
         rd(adr(s, 1'b1, 0), v); check(v == 0, "R1 length reset", v, 0);
         rd(adr(s, 1'b1, 1), v); check(v == 0, "R1 ctrl reset", v, 0);
      end
      check(tx_valid == 0 && irq == 0, "R1 outputs reset", {tx_valid, irq}, 0);
      check(station_addr == 0, "R1 station reset", station_addr, 0);

      // R2 table-driven frames
      foreach (VEC[k]) begin
         int slot = int'(VEC[k][24]);
         bit ie = VEC[k][25];
         int len = int'(VEC[k][15:0]);
         logic [7:0] seed = VEC[k][23:16];
         fill(slot, len, seed);
         wr(adr(slot, 1'b1, 0), 32'(len));
         cap_n = 0; i0 = irq_cnt;
         wr(adr(slot, 1'b1, 1), ie ? 32'h9 : 32'h1);
         wait_idle(slot);
         rd(adr(slot, 1'b1, 1), v);
         check(v[0] == 0, "R2 busy cleared", v, 0);
         check(cap_n == len, "R2 byte count", cap_n, len);
         cmp_frame(0, len, seed, "R2 data");
         check(irq_cnt - i0 == int'(ie), "R8 irq per enable", irq_cnt - i0, ie);
      end

      // R5 length readback
      wr(adr(1, 1'b1, 0), 32'hABCD_1234);
      rd(adr(1, 1'b1, 0), v);
      check(v == 32'h0000_1234, "R5 length width", v, 32'h1234);

      // R6 zero length with interrupt
      wr(adr(1, 1'b1, 0), 32'h0);
      cap_n = 0; i0 = irq_cnt;
      wr(adr(1, 1'b1, 1), 32'h9);
      wait_idle(1);
      rd(adr(1, 1'b1, 1), v);
      check(v[0] == 0, "R6 busy cleared", v, 0);
      check(cap_n == 0, "R6 no bytes", cap_n, 0);
      check(irq_cnt - i0 == 1, "R8 zero-length irq", irq_cnt - i0, 1);

      // R7 station address programming
      wr(adr(0, 1'b1, 0), 32'd6);
      wr(adr(0, 1'b0, 0), 32'h4433_2211);
      wr(adr(0, 1'b0, 1), 32'hAAAA_6655);
      cap_n = 0;
      wr(adr(0, 1'b1, 1), 32'h3);
      wait_idle(0);
      check(station_addr == 48'h6655_4433_2211, "R7 station value", station_addr, 48'h665544332211);
      rd(adr(0, 1'b1, 1), v);
      check(v[1:0] == 0, "R7 bits cleared", v, 0);
      check(cap_n == 0, "R7 no bytes", cap_n, 0);

      // R10 slot armed during another frame waits its turn
      tx_ready = 1'b0;
      fill(1, 3, 8'h40); wr(adr(1, 1'b1, 0), 32'd3);
      fill(0, 2, 8'h90); wr(adr(0, 1'b1, 0), 32'd2);
      wr(adr(1, 1'b1, 1), 32'h1);
      wr(adr(0, 1'b1, 1), 32'h1);
      repeat (4) @(negedge clk);
      check(tx_valid == 1 && tx_data == pat(8'h40, 0), "R10 first armed first",
            {tx_valid, tx_data}, {1'b1, pat(8'h40, 0)});
      rd(adr(0, 1'b1, 1), v);
      check(v[0] == 1, "R10 second waits", v, 1);
      cap_n = 0;
      tx_ready = 1'b1;
      wait_idle(1); wait_idle(0);
      check(cap_n == 5, "R10 total bytes", cap_n, 5);
      cmp_frame(0, 3, 8'h40, "R10 order first");
      cmp_frame(3, 2, 8'h90, "R10 order second");

      // R9 cancel active and pending
      tx_ready = 1'b0;
      fill(0, 4, 8'h10); wr(adr(0, 1'b1, 0), 32'd4);
      fill(1, 2, 8'h20); wr(adr(1, 1'b1, 0), 32'd2);
      i0 = irq_cnt;
      wr(adr(0, 1'b1, 1), 32'h9);
      wr(adr(1, 1'b1, 1), 32'h9);
      repeat (2) @(negedge clk);
      check(tx_valid == 1, "R9 frame active", tx_valid, 1);
      wr(adr(1, 1'b1, 1), 32'h0);
      check(tx_valid == 1, "R9 pending cancel keeps active", tx_valid, 1);
      wr(adr(0, 1'b1, 1), 32'h0);
      check(tx_valid == 0, "R9 active stopped", tx_valid, 0);
      cap_n = 0;
      tx_ready = 1'b1;
      repeat (10) @(negedge clk);
      check(cap_n == 0, "R9 nothing sent", cap_n, 0);
      check(irq_cnt == i0, "R9 no irq", irq_cnt - i0, 0);
      rd(adr(0, 1'b1, 1), v); check(v == 0, "R9 slot0 idle", v, 0);
      rd(adr(1, 1'b1, 1), v); check(v == 0, "R9 slot1 idle", v, 0);

      // R11 single-slot build ignores slot 1
      s_valid_cnt = 0;
      wr(adr(1, 1'b1, 0), 32'd4);
      wr(adr(1, 1'b1, 1), 32'h1);
      rd(adr(1, 1'b1, 1), v);
      check(s_rd_data == 0, "R11 slot1 ctrl absent", s_rd_data, 0);
      rd(adr(1, 1'b1, 0), v);
      check(s_rd_data == 0, "R11 slot1 length absent", s_rd_data, 0);
      repeat (10) @(negedge clk);
      check(s_valid_cnt == 0, "R11 no traffic", s_valid_cnt, 0);
      wait_idle(1);

      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule